// File: doc/BRIEF.md
# Fused micro-op execution unit

This block executes the single micro-op that an upstream fusion stage forms from a pair of adjacent integer instructions. In one operation it computes the 64-bit value that the second instruction of the pair would have written. That includes the word-format rules of a 64-bit machine: a 32-bit result is sign-extended into the upper half. A fused-op code selects the idiom, and a 2-bit selector picks its shift amount, extract width or logic function. Two 64-bit source operands supply the data.

An operation is presented with `valid_i` high. The result is captured in a register and appears on `result_o` one clock later, with `valid_o` high. When `valid_i` is low the result register keeps its last value. Fusion detection, operand fetch and exceptions belong to neighbouring blocks.

Top module: `fuse_exec_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0, whatever the inputs.
- R2: `valid_o` equals `valid_i` of the previous cycle. `result_o` loads only in a cycle after `valid_i` was high, and otherwise holds its value.
- R3: Op 0 returns `src1_i[15:0]` zero-extended to 64 bits. Op 1 returns the same 16 bits sign-extended from bit 15.
- R4: Op 2 returns `src2_i + (src1_i << (sel_i+1))`, so selector 0..3 gives shifts of 1..4.
- R5: Op 3 returns `src1_i[31:0]` zero-extended and then shifted left by `sel_i+1` for selector 0..2. Selector 3 returns zero.
- R6: Op 4 places `src1_i[15:8]` in bits 7:0, and all other bits are zero.
- R7: Op 5 returns `src2_i + (src1_i >> (29+sel_i))`, a logical shift of 29..32.
- R8: Op 6 returns `src2_i + src1_i[0]`. When `sel_i[0]` is 1, it returns the low 32 bits of that sum sign-extended instead.
- R9: Op 7 returns `src1_i` with bits 7:0 cleared, ORed with `src2_i`.
- R10: Op 8 multiplies `src1_i[6:0]` by `src2_i[31:0]` and returns the low 32 bits of the product sign-extended.
- R11: Op 9 forms the 32-bit sum `src1_i[31:0]+src2_i[31:0]` and extracts from it by selector: 0 bit 0, 1 the low byte, 2 the low 16 bits zero-extended, 3 the low 16 bits sign-extended.
- R12: Ops 10 and 11 first apply a logic function chosen by selector: 0 AND, 1 OR, 2 XOR of the sources, or 3 byte-wise OR-combine of `src1_i`, where each byte becomes 0xFF if it is non-zero and 0x00 otherwise. Op 10 then keeps bit 0 of the result, and op 11 keeps the low 16 bits zero-extended.
- R13: Op codes 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Fused-op code |
| sel_i | input | 2 | Shift, extract or logic-function selector |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 64 | Registered result |

## Verification
The clocked properties assume that `valid_i`, `op_i` and `sel_i` are stable and known at each rising edge. They also assume that an operation's result is judged only in the cycle after its `valid_i`, because the result register is allowed to hold stale data while idle. The bench changes every input at the falling edge and lowers `valid_i` between operations. This keeps each property's trigger cycle unambiguous. It also lets the hold check drive a different op code and different operands while idle, and then confirm that nothing leaks into the result.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned FU_BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_ZEXT_H    = 4'd0,
    OP_SEXT_H    = 4'd1,
    OP_SH_ADD    = 4'd2,
    OP_ZEXTW_SHL = 4'd3,
    OP_BYTE1     = 4'd4,
    OP_SHR_ADD   = 4'd5,
    OP_ODD_ADD   = 4'd6,
    OP_MERGE_LB  = 4'd7,
    OP_MUL7      = 4'd8,
    OP_ADDW_EXT  = 4'd9,
    OP_LOGIC_LSB = 4'd10,
    OP_LOGIC_H16 = 4'd11
  } fop_e;

  // encoding matches the selector of the add-word-extract op
  typedef enum logic [1:0] {
    EXT_BIT0 = 2'd0,
    EXT_BYTE = 2'd1,
    EXT_ZH   = 2'd2,
    EXT_SH   = 2'd3
  } ext_mode_e;
endpackage

// File: rtl/fuse_addshift.sv
module fuse_addshift
  import fuse_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned SHR_BASE = 29
) (
  input  fop_e              op_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [2:0]        shl_amt;
  logic [SH_W-1:0]   shr_amt;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] zext_word;

  assign shl_amt   = {1'b0, sel_i} + 3'd1;
  assign shr_amt   = SH_W'(SHR_BASE) + SH_W'(sel_i);
  assign zext_word = {{(DATA_W-WORD_W){1'b0}}, a_i[WORD_W-1:0]};

  // one adder shared by every add-type idiom
  always_comb begin
    unique case (op_i)
      OP_SH_ADD:  addend = a_i << shl_amt;
      OP_SHR_ADD: addend = a_i >> shr_amt;
      OP_ODD_ADD: addend = {{(DATA_W-1){1'b0}}, a_i[0]};
      default:    addend = '0;
    endcase
  end

  assign sum = b_i + addend;

  always_comb begin
    unique case (op_i)
      OP_SH_ADD, OP_SHR_ADD: res_o = sum;
      OP_ODD_ADD:
        res_o = sel_i[0] ? {{(DATA_W-WORD_W){sum[WORD_W-1]}}, sum[WORD_W-1:0]} : sum;
      OP_ZEXTW_SHL:
        res_o = (sel_i == 2'd3) ? '0 : (zext_word << shl_amt);
      OP_MERGE_LB:
        res_o = {a_i[DATA_W-1:FU_BYTE_W], {FU_BYTE_W{1'b0}}} | b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/fuse_extract.sv
module fuse_extract
  import fuse_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 16
) (
  input  fop_e              op_i,
  input  logic [1:0]        sel_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  // only the low half of the word sum can reach the result
  logic [HALF_W-1:0] sum_lo;
  logic [HALF_W-1:0] src;
  ext_mode_e         mode;

  assign sum_lo = a_i + b_i;

  always_comb begin
    src  = a_i;
    mode = EXT_ZH;
    unique case (op_i)
      OP_SEXT_H:   mode = EXT_SH;
      OP_BYTE1: begin
        src  = {{(HALF_W-FU_BYTE_W){1'b0}}, a_i[HALF_W-1 -: FU_BYTE_W]};
        mode = EXT_BYTE;
      end
      OP_ADDW_EXT: begin
        src  = sum_lo;
        mode = ext_mode_e'(sel_i);
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (mode)
      EXT_BIT0: res_o = {{(DATA_W-1){1'b0}}, src[0]};
      EXT_BYTE: res_o = {{(DATA_W-FU_BYTE_W){1'b0}}, src[FU_BYTE_W-1:0]};
      EXT_ZH:   res_o = {{(DATA_W-HALF_W){1'b0}}, src};
      default:  res_o = {{(DATA_W-HALF_W){src[HALF_W-1]}}, src};
    endcase
  end
endmodule

// File: rtl/fuse_logic.sv
module fuse_logic
  import fuse_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 16
) (
  input  fop_e              op_i,
  input  logic [1:0]        sel_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NBYTES = HALF_W / FU_BYTE_W;

  logic [HALF_W-1:0] orc;
  logic [HALF_W-1:0] lop;

  for (genvar g = 0; g < NBYTES; g++) begin : g_orc
    assign orc[g*FU_BYTE_W +: FU_BYTE_W] = {FU_BYTE_W{|a_i[g*FU_BYTE_W +: FU_BYTE_W]}};
  end

  always_comb begin
    unique case (sel_i)
      2'd0:    lop = a_i & b_i;
      2'd1:    lop = a_i | b_i;
      2'd2:    lop = a_i ^ b_i;
      default: lop = orc;
    endcase
  end

  assign res_o = (op_i == OP_LOGIC_LSB) ? {{(DATA_W-1){1'b0}}, lop[0]}
                                        : {{(DATA_W-HALF_W){1'b0}}, lop};
endmodule

// File: rtl/fuse_mul7.sv
module fuse_mul7 #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NARROW_W = 7
) (
  input  logic [NARROW_W-1:0] a_i,
  input  logic [WORD_W-1:0]   b_i,
  output logic [DATA_W-1:0]   res_o
);
  logic [WORD_W-1:0] prod;

  assign prod  = {{(WORD_W-NARROW_W){1'b0}}, a_i} * b_i;
  assign res_o = {{(DATA_W-WORD_W){prod[WORD_W-1]}}, prod};
endmodule

// File: rtl/fuse_exec_unit.sv
module fuse_exec_unit
  import fuse_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned NARROW_W = 7,
  parameter int unsigned SHR_BASE = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned UP_H = DATA_W - HALF_W;
  localparam int unsigned UP_W = DATA_W - WORD_W;

  fop_e              op;
  logic [DATA_W-1:0] as_res, ext_res, log_res, mul_res, nxt;

  assign op = fop_e'(op_i);

  fuse_addshift #(.DATA_W(DATA_W), .WORD_W(WORD_W), .SHR_BASE(SHR_BASE)) i_addshift (
    .op_i(op), .sel_i(sel_i), .a_i(src1_i), .b_i(src2_i), .res_o(as_res)
  );

  fuse_extract #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_extract (
    .op_i(op), .sel_i(sel_i), .a_i(src1_i[HALF_W-1:0]), .b_i(src2_i[HALF_W-1:0]),
    .res_o(ext_res)
  );

  fuse_logic #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_logic (
    .op_i(op), .sel_i(sel_i), .a_i(src1_i[HALF_W-1:0]), .b_i(src2_i[HALF_W-1:0]),
    .res_o(log_res)
  );

  fuse_mul7 #(.DATA_W(DATA_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) i_mul7 (
    .a_i(src1_i[NARROW_W-1:0]), .b_i(src2_i[WORD_W-1:0]), .res_o(mul_res)
  );

  always_comb begin
    unique case (op)
      OP_ZEXT_H, OP_SEXT_H, OP_BYTE1, OP_ADDW_EXT:               nxt = ext_res;
      OP_SH_ADD, OP_ZEXTW_SHL, OP_SHR_ADD, OP_ODD_ADD, OP_MERGE_LB: nxt = as_res;
      OP_LOGIC_LSB, OP_LOGIC_H16:                                nxt = log_res;
      OP_MUL7:                                                   nxt = mul_res;
      default:                                                   nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R2
  AST_ZEXT_HALF_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0) |=> result_o[DATA_W-1:HALF_W] == '0); // R3
  AST_SEXT_HALF_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd1) |=> result_o[DATA_W-1:HALF_W] == {UP_H{result_o[HALF_W-1]}}); // R3
  AST_BYTE1_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd4) |=> result_o[DATA_W-1:FU_BYTE_W] == '0); // R6
  AST_MUL7_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8) |=> result_o[DATA_W-1:WORD_W] == {UP_W{result_o[WORD_W-1]}}); // R10
  AST_LOGIC_LSB_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd10) |=> result_o[DATA_W-1:1] == '0); // R12
  AST_UNKNOWN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd12) |=> result_o == '0); // R13
endmodule

// File: tb/test_fuse_exec_unit.sv
`timescale 1ns/1ps
module test_fuse_exec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  sel_i = '0;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] last_exp = '0;

  always #2 clk_i = ~clk_i;

  fuse_exec_unit i_fuse_exec_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .sel_i(sel_i),
    .src1_i(src1_i), .src2_i(src2_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] orc64(logic [63:0] x);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = (x[k*8 +: 8] != 8'h00) ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] sx32(logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [63:0] model(int op, int sel, logic [63:0] a, logic [63:0] b);
    logic [63:0] t;
    case (op)
      0: return a & 64'hFFFF;
      1: return {{48{a[15]}}, a[15:0]};
      2: return b + a * (64'd1 << (sel + 1));
      3: return (sel == 3) ? 64'd0 : (a & 64'hFFFF_FFFF) * (64'd1 << (sel + 1));
      4: return (a >> 8) & 64'hFF;
      5: return b + (a >> (29 + sel));
      6: begin
        t = b + (a & 64'd1);
        return ((sel & 1) != 0) ? sx32(t) : t;
      end
      7: return (a & ~64'hFF) | b;
      8: return sx32((a & 64'h7F) * (b & 64'hFFFF_FFFF));
      9: begin
        t = (a + b) & 64'hFFFF_FFFF;
        case (sel)
          0: return t & 64'h1;
          1: return t & 64'hFF;
          2: return t & 64'hFFFF;
          default: return {{48{t[15]}}, t[15:0]};
        endcase
      end
      10, 11: begin
        case (sel)
          0: t = a & b;
          1: t = a | b;
          2: t = a ^ b;
          default: t = orc64(a);
        endcase
        return (op == 10) ? (t & 64'h1) : (t & 64'hFFFF);
      end
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // issue one op, sample its result at the following falling edge
  task automatic do_op(string req, int op, int sel, logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 4'(op); sel_i = 2'(sel); src1_i = a; src2_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    last_exp = model(op, sel, a, b);
    check("R2", "valid_o", {63'd0, valid_o}, 64'd1);
    check(req, $sformatf("op %0d sel %0d", op, sel), result_o, last_exp);
  endtask

  task automatic t_reset;
    valid_i = 1'b1; op_i = 4'd0; src1_i = 64'hFFFF; src2_i = 64'h1;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", "valid_o in reset", {63'd0, valid_o}, 64'd0);
    check("R1", "result_o in reset", result_o, 64'd0);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_hold;
    do_op("R9", 7, 0, 64'hAAAA_5555_1234_5678, 64'h0F);
    @(negedge clk_i);
    op_i = 4'd2; sel_i = 2'd1; src1_i = 64'h1111; src2_i = 64'h2222;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R2", "valid_o idle", {63'd0, valid_o}, 64'd0);
    check("R2", "result held idle", result_o, last_exp);
  endtask

  task automatic t_half;
    do_op("R3", 0, 0, 64'h1234_5678_9ABC_F00D, 64'h5);
    do_op("R3", 1, 0, 64'h1234_5678_9ABC_F00D, 64'h5);
    do_op("R3", 1, 2, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0);
  endtask

  task automatic t_shift_add;
    for (int s = 0; s < 4; s++) do_op("R4", 2, s, 64'hF0E1_D2C3_B4A5_8796, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_zext_word;
    for (int s = 0; s < 4; s++) do_op("R5", 3, s, 64'hDEAD_BEEF_8000_0001, 64'h77);
  endtask

  task automatic t_byte;
    do_op("R6", 4, 0, 64'hFFFF_FFFF_FFFF_A5FF, 64'h1);
    do_op("R6", 4, 3, 64'h0000_0000_0000_00FF, 64'h1);
  endtask

  task automatic t_shr_add;
    for (int s = 0; s < 4; s++) do_op("R7", 5, s, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10);
  endtask

  task automatic t_odd;
    do_op("R8", 6, 0, 64'h3, 64'h0000_0000_7FFF_FFFF);
    do_op("R8", 6, 1, 64'h3, 64'h0000_0000_7FFF_FFFF);
    do_op("R8", 6, 1, 64'h2, 64'h1234_5678_0000_0010);
    do_op("R8", 6, 0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_merge;
    do_op("R9", 7, 2, 64'h1234_5678_9ABC_DEFF, 64'h8000_0000_0000_0042);
  endtask

  task automatic t_mul;
    do_op("R10", 8, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0200_0000);
    do_op("R10", 8, 0, 64'h0000_0000_0000_0085, 64'hFFFF_FFFF_0000_0003);
  endtask

  task automatic t_addw_ext;
    for (int s = 0; s < 4; s++) do_op("R11", 9, s, 64'h5555_0000_0000_7FFF, 64'h1);
    do_op("R11", 9, 1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0180);
  endtask

  task automatic t_logic;
    for (int s = 0; s < 4; s++) do_op("R12", 10, s, 64'h0000_0000_0000_1203, 64'h0000_0000_0000_0E01);
    for (int s = 0; s < 4; s++) do_op("R12", 11, s, 64'hFFFF_0000_0100_F00F, 64'h1234_5678_0FF0_0FF0);
    do_op("R12", 11, 3, 64'hFFFF_0000_0000_0000, 64'h0);
  endtask

  task automatic t_unknown;
    for (int o = 12; o < 16; o++) do_op("R13", o, o & 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_half();
    t_shift_add();
    t_zext_word();
    t_byte();
    t_shr_add();
    t_odd();
    t_merge();
    t_mul();
    t_addw_ext();
    t_logic();
    t_unknown();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule